// File: doc/BRIEF.md
# Three-Cell-Per-Pin Boundary Scan Register

This block is the boundary-scan data register for a group of N bidirectional pins. A test access port controller supplies the scan clock and the capture, shift and update strobes, together with a mode select that chooses between test drive of the pins and normal operation. Each full pin has three scan cells: one for the value seen at the pad, one for the core's output value, and one for the core's output enable. Each scan cell has its own holding latch. When the test-drive mode is selected, the holding latches drive the pad output and the pad enable. Otherwise the core's values reach the pads directly.

Three fixed cells that belong to no pin frame the chain. Two sit next to serial out and hold a scan-output enable and a scan-output value. One sits next to serial in and holds an update-control flag. The held values of these three cells are brought out for use nearby. The around-the-die placement of the pins is reduced to a linear pin index. A per-pin kind parameter removes the cells that an input-only or output-only pin does not have.

Top module: `pin_scan_register`

## Requirements
- R1: The chain length is 3 plus the number of populated pin cells (12 with the default kinds). A bit entering at `tdi_i` appears at `tdo_o` after exactly that many shift clocks.
- R2: Chain position 0 is at `tdo_o`. Position 0 is the scan-output enable cell and position 1 is the scan-output value cell. Pin groups follow in increasing pin index, and each group is ordered input cell, output cell, enable cell. The last position, next to `tdi_i`, is the update-control cell.
- R3: While `shift_i` is high, each clock moves the chain one position toward `tdo_o`, and `tdi_i` enters the last position. `capture_i` takes priority over `shift_i`. When neither strobe is high, the chain holds its contents.
- R4: On a clock with `capture_i` high, every input cell loads its pad value and every output cell and enable cell loads the core's output and enable for that pin. Each of the three fixed cells loads its own held value.
- R5: The holding latches load from the chain only on a clock with `update_i` high. Shift and capture leave the pad drive unchanged.
- R6: With `extest_i` high, each pin that has output cells drives `pad_out_o` from its held output value and `pad_oe_o` from its held enable value.
- R7: With `extest_i` low, each pin that has output cells passes `core_out_i` to `pad_out_o` and `core_oe_i` to `pad_oe_o`.
- R8: `PIN_KIND` holds 2 bits per pin. Bit 0 gives the pin an input cell, and bit 1 gives it an output cell and an enable cell. Absent cells take no place in the chain. A pin with no output cells drives 0 on `pad_out_o` and `pad_oe_o` in both modes. The default kinds for pins 3..0 are full, output-only, input-only and full.
- R9: While `rst_ni` is low, all chain cells and holding latches clear, so `tdo_o` and `aux_hold_o` read 0.
- R10: `aux_hold_o` bits 0, 1 and 2 give the held values of the scan-output enable cell, the scan-output value cell and the update-control cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| capture_i | input | 1 | Parallel load of the chain |
| shift_i | input | 1 | Serial shift toward tdo_o |
| update_i | input | 1 | Transfer of the chain into the holding latches |
| extest_i | input | 1 | Pins driven from the holding latches |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, chain position 0 |
| pad_in_i | input | NUM_PINS | Values seen at the pads |
| core_out_i | input | NUM_PINS | Core output values |
| core_oe_i | input | NUM_PINS | Core output enables |
| pad_out_o | output | NUM_PINS | Value driven to each pad |
| pad_oe_o | output | NUM_PINS | Drive enable for each pad |
| aux_hold_o | output | 3 | Held values of the three fixed cells |

## Verification
The bench captures distinct pad and core patterns and checks that each value leaves at the serial position its pin kind implies. A chain that skipped absent cells wrongly, or that swapped the output and enable cells, would produce a pattern at `tdo_o` that is displaced or has bits exchanged. A single marker bit is timed from `tdi_i` to `tdo_o`, which catches an extra or missing stage. Capture and shift are raised together; a design that lets shift win shows a neighbouring bit on `tdo_o` instead of the captured one. The pads are also checked after a full shift with no update, and after switching out of test-drive mode. This catches a design that lets shifting reach the pins, or that drives an input-only pin.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int MAX_PINS = 64;
  typedef logic [2*MAX_PINS-1:0] pin_cfg_t;

  // kind bit0: input cell, bit1: output + enable cells
  function automatic int cells_of(logic [1:0] kind);
    return (kind[0] ? 1 : 0) + (kind[1] ? 2 : 0);
  endfunction

  // first chain position of a pin group; positions 0 and 1 are fixed cells
  function automatic int pin_base(pin_cfg_t cfg, int pin);
    int b = 2;
    for (int p = 0; p < pin; p++) b += cells_of(cfg[2*p +: 2]);
    return b;
  endfunction

  function automatic int chain_len(pin_cfg_t cfg, int n_pins);
    return pin_base(cfg, n_pins) + 1;
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_d_i,
  input  logic ser_d_i,
  output logic ser_q_o,
  output logic hold_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_q_o <= 1'b0;
    else if (capture_i) ser_q_o <= cap_d_i;
    else if (shift_i) ser_q_o <= ser_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q_o <= 1'b0;
    else if (update_i) hold_q_o <= ser_q_o;
  end
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux #(
  parameter bit HAS_OUT = 1'b1
) (
  input  logic extest_i,
  input  logic core_out_i,
  input  logic core_oe_i,
  input  logic hold_out_i,
  input  logic hold_oe_i,
  output logic pad_out_o,
  output logic pad_oe_o
);
  if (HAS_OUT) begin : g_drv
    assign pad_out_o = extest_i ? hold_out_i : core_out_i;
    assign pad_oe_o  = extest_i ? hold_oe_i  : core_oe_i;
  end else begin : g_quiet
    assign pad_out_o = 1'b0;
    assign pad_oe_o  = 1'b0;
  end
endmodule

// File: rtl/pin_scan_register.sv
module pin_scan_register #(
  parameter int                    NUM_PINS = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KIND = 8'b11_10_01_11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                shift_i,
  input  logic                update_i,
  input  logic                extest_i,
  input  logic                tdi_i,
  output logic                tdo_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] core_out_i,
  input  logic [NUM_PINS-1:0] core_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [2:0]          aux_hold_o
);
  localparam bsr_pkg::pin_cfg_t CFG = bsr_pkg::pin_cfg_t'(PIN_KIND);
  localparam int LEN = bsr_pkg::chain_len(CFG, NUM_PINS);

  logic [LEN-1:0] ser_q, hold_q, cap_d, ser_d;

  assign ser_d = {tdi_i, ser_q[LEN-1:1]};
  assign tdo_o = ser_q[0];

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    bsr_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .capture_i(capture_i),
      .shift_i  (shift_i),
      .update_i (update_i),
      .cap_d_i  (cap_d[i]),
      .ser_d_i  (ser_d[i]),
      .ser_q_o  (ser_q[i]),
      .hold_q_o (hold_q[i])
    );
  end

  // fixed cells recapture their own held value
  assign cap_d[0]     = hold_q[0];
  assign cap_d[1]     = hold_q[1];
  assign cap_d[LEN-1] = hold_q[LEN-1];
  assign aux_hold_o   = {hold_q[LEN-1], hold_q[1], hold_q[0]};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int B   = bsr_pkg::pin_base(CFG, p);
    localparam bit HI  = CFG[2*p];
    localparam bit HO  = CFG[2*p+1];
    localparam int OFS = B + (HI ? 1 : 0);

    logic h_out, h_oe;

    if (HI) begin : g_in
      assign cap_d[B] = pad_in_i[p];
    end
    if (HO) begin : g_out
      assign cap_d[OFS]   = core_out_i[p];
      assign cap_d[OFS+1] = core_oe_i[p];
      assign h_out        = hold_q[OFS];
      assign h_oe         = hold_q[OFS+1];
    end else begin : g_noout
      assign h_out = 1'b0;
      assign h_oe  = 1'b0;
    end

    bsr_pad_mux #(.HAS_OUT(HO)) u_mux (
      .extest_i  (extest_i),
      .core_out_i(core_out_i[p]),
      .core_oe_i (core_oe_i[p]),
      .hold_out_i(h_out),
      .hold_oe_i (h_oe),
      .pad_out_o (pad_out_o[p]),
      .pad_oe_o  (pad_oe_o[p])
    );
  end
endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
  parameter int                    NUM_PINS = 4,
  parameter logic [2*NUM_PINS-1:0] PIN_KIND = 8'b11_10_01_11
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                capture_i,
  input logic                shift_i,
  input logic                update_i,
  input logic                extest_i,
  input logic                tdo_o,
  input logic [NUM_PINS-1:0] core_out_i,
  input logic [NUM_PINS-1:0] core_oe_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [2:0]          aux_hold_o
);
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !shift_i) |=> $stable(tdo_o));

  a_r4_capture_fixed_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> tdo_o == $past(aux_hold_o[0]));

  a_r5_pads_wait_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (extest_i && !update_i) |=> (extest_i -> ($stable(pad_out_o) && $stable(pad_oe_o))));

  a_r10_aux_wait_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(aux_hold_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r9_reset_clear: assert (tdo_o == 1'b0 && aux_hold_o == 3'b000);
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (PIN_KIND[2*p+1]) begin : g_out
      a_r7_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !extest_i |-> (pad_out_o[p] == core_out_i[p] && pad_oe_o[p] == core_oe_i[p]));
    end else begin : g_noout
      a_r8_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_out_o[p] == 1'b0 && pad_oe_o[p] == 1'b0));
    end
  end
endmodule

bind pin_scan_register bsr_chk #(.NUM_PINS(NUM_PINS), .PIN_KIND(PIN_KIND)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .extest_i  (extest_i),
  .tdo_o     (tdo_o),
  .core_out_i(core_out_i),
  .core_oe_i (core_oe_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .aux_hold_o(aux_hold_o)
);

// File: tb/sim_pin_scan_register.sv
`timescale 1ns/1ps
module sim_pin_scan_register;
  localparam int N   = 4;
  localparam int LEN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture = 0, shift = 0, update = 0, extest = 0, tdi = 0;
  logic tdo;
  logic [N-1:0] pad_in = '0, core_out = '0, core_oe = '0;
  logic [N-1:0] pad_out, pad_oe;
  logic [2:0] aux;

  int n_chk = 0;
  int n_bad = 0;
  logic [LEN-1:0] pat;

  always #5 clk = ~clk;

  pin_scan_register #(.NUM_PINS(N), .PIN_KIND(8'b11_10_01_11)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .extest_i(extest), .tdi_i(tdi), .tdo_o(tdo),
    .pad_in_i(pad_in), .core_out_i(core_out), .core_oe_i(core_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .aux_hold_o(aux)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R2 layout: chain image expected from a capture
  function automatic logic [LEN-1:0] cap_img(logic [2:0] a, logic [N-1:0] pi,
                                              logic [N-1:0] co, logic [N-1:0] ce);
    return {a[2], ce[3], co[3], pi[3], ce[2], co[2], pi[1], ce[0], co[0], pi[0], a[1], a[0]};
  endfunction

  task automatic scan(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      dout[i] = tdo;
      tdi = din[i];
      shift = 1'b1;
    end
    @(negedge clk);
    shift = 1'b0;
  endtask

  task automatic pulse_capture();
    @(negedge clk); capture = 1'b1;
    @(negedge clk); capture = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update = 1'b1;
    @(negedge clk); update = 1'b0;
  endtask

  task automatic t_reset();
    extest = 1'b1;
    @(negedge clk);
    chk("R9 tdo", 16'(tdo), 16'h0);
    chk("R9 aux", 16'(aux), 16'h0);
    chk("R9 pad_out", 16'(pad_out), 16'h0);
    chk("R9 pad_oe", 16'(pad_oe), 16'h0);
  endtask

  task automatic t_capture();
    logic [LEN-1:0] got;
    pad_in = 4'b1011; core_out = 4'b0110; core_oe = 4'b1101;
    pulse_capture();
    chk("R4 capture tdo bit0", 16'(tdo), 16'h0);
    pat = 12'hA59;
    scan(pat, got);
    chk("R2 R4 captured image", 16'(got), 16'(cap_img(3'b000, 4'b1011, 4'b0110, 4'b1101)));
  endtask

  task automatic t_update_extest();
    chk("R5 pad_out before update", 16'(pad_out), 16'h0);
    chk("R5 pad_oe before update", 16'(pad_oe), 16'h0);
    pulse_update();
    chk("R6 pad_out", 16'(pad_out), 16'({pat[9], pat[6], 1'b0, pat[3]}));
    chk("R6 R8 pad_oe", 16'(pad_oe), 16'({pat[10], pat[7], 1'b0, pat[4]}));
    chk("R10 aux", 16'(aux), 16'({pat[11], pat[1], pat[0]}));
  endtask

  task automatic t_priority();
    logic [LEN-1:0] got;
    pad_in = 4'b0100; core_out = 4'b1001; core_oe = 4'b0011;
    @(negedge clk); capture = 1'b1; shift = 1'b1; tdi = 1'b1;
    @(negedge clk); capture = 1'b0; shift = 1'b0; tdi = 1'b0;
    chk("R3 capture wins tdo", 16'(tdo), 16'(pat[0]));
    scan('0, got);
    chk("R3 R4 captured after tie", 16'(got),
        16'(cap_img({pat[11], pat[1], pat[0]}, 4'b0100, 4'b1001, 4'b0011)));
    chk("R5 pad_out after shift", 16'(pad_out), 16'({pat[9], pat[6], 1'b0, pat[3]}));
    chk("R10 aux after shift", 16'(aux), 16'({pat[11], pat[1], pat[0]}));
  endtask

  task automatic t_length();
    int seen = -1;
    for (int k = 0; k < 40 && seen < 0; k++) begin
      @(negedge clk);
      if (tdo) seen = k;
      tdi = (k == 0);
      shift = 1'b1;
    end
    @(negedge clk); shift = 1'b0; tdi = 1'b0;
    chk("R1 R3 marker latency", 16'(seen), 16'(LEN));
  endtask

  task automatic t_passthrough();
    extest = 1'b0; core_out = 4'b1010; core_oe = 4'b0111;
    @(negedge clk);
    chk("R7 R8 pad_out", 16'(pad_out), 16'(4'b1010 & 4'b1101));
    chk("R7 R8 pad_oe", 16'(pad_oe), 16'(4'b0111 & 4'b1101));
    extest = 1'b1;
    @(negedge clk);
    chk("R6 back to held", 16'(pad_out), 16'({pat[9], pat[6], 1'b0, pat[3]}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_capture();
    t_update_extest();
    t_priority();
    t_length();
    t_passthrough();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule